// File: doc/BRIEF.md
# Audio Routing Crossbar with Sample-Rate Prescaler

This block connects four stereo audio sources (DMA playback, DSP transmit, external input, A/D converter) to four destinations (external output, DAC, DMA record, DSP receive). Each destination picks one source through a 2-bit select. Each source is paced by one of three master clock domains. Each domain has a sample strobe derived from its master clock ticks. Every path can run with a valid/ready handshake or with the handshake turned off. The DAC path also has a mixer that can add the A/D converter stream to the routed stream, with saturation.

Software programs the block through a small synchronous register bus. Master clocks enter as single-cycle tick enables in the `clk` domain, one per domain. A sample is a 32-bit word: left channel in bits 31:16, right channel in bits 15:0, both signed 16-bit.

Register map (`addr`):
- 0: source config
- 1: destination config
- 2: external prescale
- 3: internal prescale
- 4: mixer select
- 5: overflow status, cleared by any write

Source config holds one nibble per source i, at bits 4i+3..4i:
- bit 4i: handshake off
- bits 4i+2..4i+1: clock code
- bit 7: DSP transmit connect

Destination config holds one nibble per destination j, at bits 4j+3..4j:
- bit 4j: handshake off
- bits 4j+2..4j+1: source code
- bit 15: DSP receive connect

Top module: `audio_xbar`

## Requirements
- R1: Destination source code 00 selects DMA playback (source 0), 01 DSP transmit (source 1), 10 external input (source 2), 11 A/D converter (source 3). A taken sample appears on `dst_data` with `dst_valid` high for one cycle, one clock after the strobe of the selected source.
- R2: Source clock code 00 follows strobe domain 0 (internal 25.175 MHz ticks), 01 domain 1 (external ticks), 10 domain 2 (internal 32 MHz ticks), and 11 never strobes. `src_ready[i]` is high exactly in the cycles where the selected strobe is high.
- R3: With prescale N from 1 to 15, a domain strobe is a one-cycle pulse every 256*(N+1) ticks. Domain 1 uses the external prescale and domains 0 and 2 use the internal prescale.
- R4: Prescale N = 0 selects the legacy fixed rate: one strobe every LEGACY_DIV ticks (default 1536).
- R5: A prescale write keeps only bits 3:0. The upper bits read back as zero and do not affect the rate.
- R6: With handshake on, a destination takes a sample only when its source is valid (or that source has handshake off) and `dst_ready` is high.
- R7: With destination handshake off, the destination takes a sample on every strobe, regardless of source valid and `dst_ready`.
- R8: DSP transmit connect at 0 means no destination receives from source 1. DSP receive connect at 0 means destination 3 never outputs valid. Both bits reset to 0.
- R9: Mixer select bit 1 routes the matrix stream to the DAC (destination 1) and bit 0 routes the A/D stream. With both bits set, the DAC gets the per-channel sum, saturated to the signed 16-bit range. With neither set, the DAC gets zero.
- R10: A saturating DAC sum sets sticky status bit 1 for the left channel and bit 0 for the right channel. Any write to address 5 clears both bits.
- R11: After reset all registers read zero and no destination is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (write and read) |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data, combinational from addr |
| clk_tick | input | 3 | Master clock tick per domain |
| strobe | output | 3 | Sample strobe per domain |
| src_valid | input | 4 | Source sample valid |
| src_data | input | 128 | Source samples, 32 bits per source |
| src_ready | output | 4 | Source pull pulse |
| dst_valid | output | 4 | Destination sample valid |
| dst_data | output | 128 | Destination samples, 32 bits per destination |
| dst_ready | input | 4 | Destination ready |

## Verification
A domain strobe goes high one cycle after the tick that completes its count. `src_ready` follows the strobe in the same cycle. A destination sample, its valid flag and any overflow status bit appear one cycle after that strobe. The bench therefore waits at falling edges until the strobe is seen, then checks the destination outputs at the next falling edge. Strobe periods are counted between two later pulses, so the first, partial interval after a prescale change is skipped. Register read data is combinational and is checked in the same cycle the address is driven.

// File: rtl/audio_xbar.sv
module audio_xbar #(
  parameter int DW         = 16,
  parameter int PW         = 4,
  parameter int LEGACY_DIV = 1536
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [15:0]     wr_data,
  output logic [15:0]     rd_data,
  input  logic [2:0]      clk_tick,
  output logic [2:0]      strobe,
  input  logic [3:0]      src_valid,
  input  logic [8*DW-1:0] src_data,
  output logic [3:0]      src_ready,
  output logic [3:0]      dst_valid,
  output logic [8*DW-1:0] dst_data,
  input  logic [3:0]      dst_ready
);
  localparam int SW     = 2*DW;
  localparam int TOPDIV = 256 * (2**PW);
  localparam int MAXDIV = (LEGACY_DIV > TOPDIV) ? LEGACY_DIV : TOPDIV;
  localparam int CW     = $clog2(MAXDIV);

  logic [15:0]   scfg, dcfg;
  logic [PW-1:0] pre_ext, pre_int;
  logic [1:0]    mix_sel, ovf;
  logic [3:0]    src_strb, src_ok, src_conn;
  logic [SW-1:0] sd [4];
  logic [SW-1:0] mix_data;
  logic [1:0]    mix_ovf;

  wire clr_stat = wr_en && addr == 3'd5;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scfg <= '0; dcfg <= '0; pre_ext <= '0; pre_int <= '0; mix_sel <= '0;
    end else if (wr_en) begin
      case (addr)
        3'd0: scfg    <= wr_data;
        3'd1: dcfg    <= wr_data;
        3'd2: pre_ext <= wr_data[PW-1:0];
        3'd3: pre_int <= wr_data[PW-1:0];
        3'd4: mix_sel <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rd_data = scfg;
      3'd1:    rd_data = dcfg;
      3'd2:    rd_data = 16'(pre_ext);
      3'd3:    rd_data = 16'(pre_int);
      3'd4:    rd_data = {14'd0, mix_sel};
      3'd5:    rd_data = {14'd0, ovf};
      default: rd_data = '0;
    endcase
  end

  for (genvar d = 0; d < 3; d++) begin : g_dom
    logic [CW-1:0] cnt, lim;
    wire  [PW-1:0] n = (d == 1) ? pre_ext : pre_int;
    assign lim = (n == '0) ? CW'(LEGACY_DIV - 1) : CW'(256 * (int'(n) + 1) - 1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0; strobe[d] <= 1'b0;
      end else begin
        strobe[d] <= 1'b0;
        if (clk_tick[d]) begin
          if (cnt >= lim) begin
            cnt <= '0; strobe[d] <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_src
    wire [1:0] code = scfg[4*i+2 -: 2];
    assign src_strb[i] = (code == 2'd3) ? 1'b0 : strobe[code];
    assign src_ok[i]   = src_valid[i] | scfg[4*i];
    assign src_conn[i] = (i == 1) ? scfg[7] : 1'b1;
    assign sd[i]       = src_data[i*SW +: SW];
  end
  assign src_ready = src_strb;

  function automatic logic [DW:0] sat_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {a[DW-1], a} + {b[DW-1], b};
    if (s[DW] != s[DW-1])
      return {1'b1, s[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}}};
    return {1'b0, s[DW-1:0]};
  endfunction

  always_comb begin
    logic [SW-1:0] m;
    logic [DW:0]   l, r;
    m = sd[dcfg[6:5]];
    l = sat_add(m[SW-1:DW], sd[3][SW-1:DW]);
    r = sat_add(m[DW-1:0],  sd[3][DW-1:0]);
    mix_ovf = 2'b00;
    case (mix_sel)
      2'b10:   mix_data = m;
      2'b01:   mix_data = sd[3];
      2'b11: begin
        mix_data = {l[DW-1:0], r[DW-1:0]};
        mix_ovf  = {l[DW], r[DW]};
      end
      default: mix_data = '0;
    endcase
  end

  logic [3:0] take;
  for (genvar j = 0; j < 4; j++) begin : g_dst
    wire [1:0] sel  = dcfg[4*j+2 -: 2];
    wire       conn = (j == 3) ? dcfg[15] : 1'b1;
    assign take[j] = src_strb[sel] & conn & src_conn[sel] &
                     (dcfg[4*j] | (src_ok[sel] & dst_ready[j]));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dst_valid[j]          <= 1'b0;
        dst_data[j*SW +: SW]  <= '0;
      end else begin
        dst_valid[j] <= take[j];
        if (take[j]) dst_data[j*SW +: SW] <= (j == 1) ? mix_data : sd[sel];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ovf <= 2'b00;
    else if (clr_stat) ovf <= 2'b00;
    else if (take[1])  ovf <= ovf | mix_ovf;
  end
endmodule

// File: rtl/check_audio_xbar.sv
module check_audio_xbar (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  strobe,
  input logic [3:0]  src_strb,
  input logic [3:0]  dst_valid,
  input logic [15:0] scfg,
  input logic [15:0] dcfg,
  input logic [1:0]  ovf,
  input logic        wr_en,
  input logic [2:0]  addr
);
  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe[0] |=> !strobe[0]);

  p_valid_after_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid[0] |-> $past(strobe != 3'b000));

  p_dsp_rx_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dcfg[15] |=> !dst_valid[3]);

  p_hs_off_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dcfg[0] && src_strb[dcfg[2:1]] && !(dcfg[2:1] == 2'd1 && !scfg[7])) |=> dst_valid[0]);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[1] && !(wr_en && addr == 3'd5)) |=> ovf[1]);

  p_ovf_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5) |=> ovf == 2'b00);
endmodule

bind audio_xbar check_audio_xbar u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .src_strb(src_strb),
  .dst_valid(dst_valid), .scfg(scfg), .dcfg(dcfg), .ovf(ovf),
  .wr_en(wr_en), .addr(addr)
);

// File: tb/sim_audio_xbar.sv
module sim_audio_xbar;
  logic         clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0]   addr = 0, clk_tick = 3'b111;
  logic [15:0]  wr_data = 0, rd_data;
  logic [2:0]   strobe;
  logic [3:0]   src_valid = 0, src_ready, dst_valid, dst_ready = 0;
  logic [127:0] src_data = 0, dst_data;
  int n_chk = 0, n_bad = 0;

  audio_xbar u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [15:0] exp);
    @(negedge clk); addr = a; #1 chk(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic wait_strb(input int d);
    do @(negedge clk); while (!strobe[d]);
  endtask

  task automatic period(input string req, input int d, input int exp);
    int c;
    wait_strb(d); wait_strb(d);
    c = 0;
    do begin @(negedge clk); c++; end while (!strobe[d]);
    chk(req, 32'(c), 32'(exp));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 strobe", 32'(strobe), 0);
    chk("R11 dst_valid", 32'(dst_valid), 0);
    for (int a = 0; a < 6; a++) rd("R11 reg", 3'(a), 16'h0);
  endtask

  task automatic t_prescale;
    wr(3, 16'h0001); period("R3 N=1", 0, 512);
    wr(3, 16'h0003); period("R3 N=3", 0, 1024);
    wr(3, 16'h000F); period("R3 N=15", 0, 4096);
    wr(3, 16'h003A); rd("R5 readback", 3, 16'h000A);
    period("R5 upper bits ignored", 0, 2816);
    period("R4 legacy", 1, 1536);
    wr(3, 16'h0001); wr(2, 16'h0001);
  endtask

  task automatic t_clksel;
    int seen;
    clk_tick = 3'b010;
    wr(0, 16'h0002);
    wait_strb(1); chk("R2 code01 ready", 32'(src_ready[0]), 1);
    clk_tick = 3'b011;
    wr(0, 16'h0004);
    seen = 0;
    repeat (1100) begin @(negedge clk); if (src_ready[0]) seen++; end
    chk("R2 code10 no tick", 32'(seen), 0);
    clk_tick = 3'b111;
    wr(0, 16'h0006);
    seen = 0;
    repeat (1100) begin @(negedge clk); if (src_ready[0]) seen++; end
    chk("R2 code11 never", 32'(seen), 0);
    wr(0, 16'h0080);
  endtask

  task automatic t_route;
    for (int k = 0; k < 4; k++) begin
      wr(1, 16'(1 | (k << 1)));
      wait_strb(0); @(negedge clk);
      chk("R1 valid", 32'(dst_valid[0]), 1);
      chk("R1 data", dst_data[31:0], src_data[k*32 +: 32]);
    end
  endtask

  task automatic t_hs;
    wr(1, 16'h0000);
    src_valid = 0; dst_ready = 4'hF;
    wait_strb(0); @(negedge clk); chk("R6 no src valid", 32'(dst_valid[0]), 0);
    src_valid = 4'h1; dst_ready = 0;
    wait_strb(0); @(negedge clk); chk("R6 no dst ready", 32'(dst_valid[0]), 0);
    dst_ready = 4'hF;
    wait_strb(0); @(negedge clk); chk("R6 both ready", 32'(dst_valid[0]), 1);
    src_valid = 0; wr(0, 16'h0081);
    wait_strb(0); @(negedge clk); chk("R6 src hs off", 32'(dst_valid[0]), 1);
    wr(0, 16'h0080); wr(1, 16'h0001); dst_ready = 0;
    wait_strb(0); @(negedge clk); chk("R7 dst hs off", 32'(dst_valid[0]), 1);
  endtask

  task automatic t_dsp;
    wr(0, 16'h0000); wr(1, 16'h0003);
    wait_strb(0); @(negedge clk); chk("R8 tx disconnected", 32'(dst_valid[0]), 0);
    wr(0, 16'h0080); wr(1, 16'h1000);
    wait_strb(0); @(negedge clk); chk("R8 rx disconnected", 32'(dst_valid[3]), 0);
    wr(1, 16'h9000);
    wait_strb(0); @(negedge clk); chk("R8 rx connected", 32'(dst_valid[3]), 1);
  endtask

  task automatic t_mix;
    src_data[64 +: 32] = {16'h7000, 16'h8000};
    src_data[96 +: 32] = {16'h2000, 16'hF000};
    wr(1, 16'h0050);
    wr(4, 16'h0002); wait_strb(0); @(negedge clk);
    chk("R9 matrix only", dst_data[63:32], {16'h7000, 16'h8000});
    wr(4, 16'h0001); wait_strb(0); @(negedge clk);
    chk("R9 adc only", dst_data[63:32], {16'h2000, 16'hF000});
    wr(4, 16'h0000); wait_strb(0); @(negedge clk);
    chk("R9 none", dst_data[63:32], 0);
    rd("R10 no ovf yet", 5, 16'h0000);
    wr(4, 16'h0003); wait_strb(0); @(negedge clk);
    chk("R9 saturated", dst_data[63:32], {16'h7FFF, 16'h8000});
    rd("R10 ovf set", 5, 16'h0003);
    src_data[64 +: 32] = {16'h1000, 16'h0100};
    wait_strb(0); @(negedge clk);
    chk("R9 plain sum", dst_data[63:32], {16'h3000, 16'hF100});
    rd("R10 sticky", 5, 16'h0003);
    wr(5, 16'h0000); rd("R10 cleared", 5, 16'h0000);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) src_data[i*32 +: 32] = 32'hA000_0000 + 32'(i * 32'h0101_0101);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_prescale; t_clksel; t_route; t_hs; t_dsp; t_mix;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule